// File: doc/BRIEF.md
# Sub-Word IO Access Adapter

This block sits between a 128-byte IO window and register blocks that accept only whole 32-bit words. A host access may be 1, 2, 3 or 4 bytes wide and may start at any byte address, as long as it stays inside one 32-bit word. The adapter decodes the address into one of three targets: a 64-byte controller-core window of sixteen words, a 32-byte DMA window of eight words, and one bus-control word that lives inside the adapter. Every other offset is unmapped.

Reads are issued downstream as whole-word reads. The requested bytes are shifted down to bit 0 and the unrequested upper bytes are cleared. A write that is narrower than a word, or that does not start on a word boundary, becomes a read-modify-write. The current word is fetched through a side-effect-free peek port, the new bytes are placed in their lanes, and one aligned full-word write goes downstream. The peek port is used because some downstream status words clear when they are read. Bit 24 of the bus-control word is exported as a mode flag that selects how downstream status is cleared.

Each request is a one-cycle `hostValid` pulse. Downstream strobes, indices and write data are combinational in the request cycle. Read data comes back on `hostRdata` with a `hostRvalid` pulse one cycle later.

Top module: `io_width_adapter`

## Requirements
- R1: Offsets 0x00 to 0x3F select the core window. The word index is address bits [5:2]. A read asserts `coreRdEn` and a write asserts `coreWrEn`, each for the request cycle only.
- R2: Offsets 0x40 to 0x5F select the DMA window. The word index is (address minus 0x40) shifted right by 2. The window is driven through `dmaRdEn` and `dmaWrEn`.
- R3: Offsets 0x70 to 0x73 address a 32-bit bus-control word inside the adapter. Reset clears it to zero. It changes only on a write to it. `clrMode` always equals its bit 24.
- R4: The unmapped offsets are 0x60 to 0x6F and 0x74 to 0x7F. A read of any of them returns zero. A write to any of them is dropped. No downstream strobe is asserted for either.
- R5: A 4-byte write to an aligned address sends the host data unchanged as the downstream write word.
- R6: A write with size 1 to 3, or with a nonzero address[1:0], is merged before it goes downstream. Host bytes 0 to size-1 go to byte lanes address[1:0] upward, and the other lanes keep the current word. The result is one aligned 32-bit write.
- R7: A read returns, one cycle after the request with `hostRvalid` high, the target word shifted right by 8 times address[1:0]. Bits at and above 8 times size are cleared.
- R8: A write never asserts a downstream read strobe. Its current word comes only from the peek ports, so a clear-on-read word is not disturbed.
- R9: An access whose size field is 0, 5, 6 or 7 is ignored. It raises no strobe, changes no word and produces no `hostRvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | One-cycle access request |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 7 | Byte offset in the IO window |
| hostSize | input | 3 | Access size in bytes (1 to 4) |
| hostWdata | input | 32 | Write data, least significant byte first |
| hostRdata | output | 32 | Read data, shifted down and masked |
| hostRvalid | output | 1 | Read data valid, one cycle after request |
| clrMode | output | 1 | Bit 24 of the bus-control word |
| coreIdx | output | 4 | Core window word index |
| coreRdEn | output | 1 | Core word read strobe |
| coreWrEn | output | 1 | Core word write strobe |
| coreWdata | output | 32 | Full word written to the core window |
| coreRdata | input | 32 | Core word read data |
| corePeekIdx | output | 4 | Core peek index |
| corePeekData | input | 32 | Side-effect-free core word value |
| dmaIdx | output | 3 | DMA window word index |
| dmaRdEn | output | 1 | DMA word read strobe |
| dmaWrEn | output | 1 | DMA word write strobe |
| dmaWdata | output | 32 | Full word written to the DMA window |
| dmaRdata | input | 32 | DMA word read data |
| dmaPeekIdx | output | 3 | DMA peek index |
| dmaPeekData | input | 32 | Side-effect-free DMA word value |

## Verification
The bench targets these corner cases:

- **Unaligned narrow writes.** This covers a byte at lane 3 and a half-word at lane 2. A lane-placement error would put the new bytes in the wrong lanes, and a merge error would zero the lanes that should be kept.
- **Narrow reads.** A missing shift would return the wrong byte. A missing mask would leave stale upper bytes.
- **Unmapped gaps.** The gaps at 0x60 to 0x6F and above 0x73 are probed with reads and writes. A decoder that folded them into a window would corrupt a register or return non-zero data.
- **Illegal sizes.** These must leave everything untouched.
- **Strobes during writes.** The downstream strobes are watched on every cycle. A design that fetched the merge word through the normal read port would raise a read strobe during a write.

// File: rtl/io_adapter_pkg.sv
package io_adapter_pkg;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_CORE = 2'd1,
    REG_DMA  = 2'd2,
    REG_CTRL = 2'd3
  } region_e;

  typedef struct packed {
    logic coreWr;
    logic coreRd;
    logic dmaWr;
    logic dmaRd;
    logic ctrlWr;
    logic rdTake;
    logic mergeOn;
  } strobe_t;

endpackage

// File: rtl/io_adapter_ctrl.sv
module io_adapter_ctrl
  import io_adapter_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int LANES     = 4,
  parameter int CORE_END  = 'h40,
  parameter int DMA_END   = 'h60,
  parameter int CTRL_ADDR = 'h70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [2:0]        hostSize,
  output region_e           region,
  output strobe_t           strobe
);

  localparam int LB = $clog2(LANES);
  localparam logic [ADDR_W-1:0] CORE_LIM = ADDR_W'(CORE_END);
  localparam logic [ADDR_W-1:0] DMA_LIM  = ADDR_W'(DMA_END);
  localparam logic [ADDR_W-LB-1:0] CTRL_WORD = (ADDR_W-LB)'(CTRL_ADDR >> LB);

  logic sizeOk;
  logic go;

  always_comb begin
    sizeOk = (hostSize != 3'd0) && (int'(hostSize) <= LANES);
    go     = hostValid && sizeOk;
    if (hostAddr < CORE_LIM)                            region = REG_CORE;
    else if (hostAddr < DMA_LIM)                        region = REG_DMA;
    else if (hostAddr[ADDR_W-1:LB] == CTRL_WORD)        region = REG_CTRL;
    else                                                region = REG_NONE;
  end

  always_comb begin
    strobe         = '0;
    strobe.coreWr  = go && hostWrite  && (region == REG_CORE);
    strobe.coreRd  = go && !hostWrite && (region == REG_CORE);
    strobe.dmaWr   = go && hostWrite  && (region == REG_DMA);
    strobe.dmaRd   = go && !hostWrite && (region == REG_DMA);
    strobe.ctrlWr  = go && hostWrite  && (region == REG_CTRL);
    strobe.rdTake  = go && !hostWrite;
    strobe.mergeOn = hostWrite && ((int'(hostSize) != LANES) || (hostAddr[LB-1:0] != '0));
  end

  // R8: a write raises no downstream read strobe
  assert_write_no_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostWrite) |-> !(strobe.coreRd || strobe.dmaRd));

  // R4: unmapped offsets raise no strobe at all
  assert_unmapped_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostAddr >= DMA_LIM && hostAddr[ADDR_W-1:LB] != CTRL_WORD)
      |-> !(strobe.coreWr || strobe.coreRd || strobe.dmaWr || strobe.dmaRd || strobe.ctrlWr));

  // R9: illegal sizes raise nothing
  assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && (hostSize == 3'd0 || int'(hostSize) > LANES))
      |-> !(strobe.coreWr || strobe.coreRd || strobe.dmaWr || strobe.dmaRd
            || strobe.ctrlWr || strobe.rdTake));

  // R1: at most one downstream access per cycle
  assert_single_target_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.coreWr, strobe.coreRd, strobe.dmaWr, strobe.dmaRd, strobe.ctrlWr}));

endmodule

// File: rtl/io_adapter_dp.sv
module io_adapter_dp
  import io_adapter_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CLR_BIT = 24
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strobe,
  input  region_e                      region,
  input  logic [$clog2(DATA_W/8)-1:0]  laneOff,
  input  logic [2:0]                   hostSize,
  input  logic [DATA_W-1:0]            hostWdata,
  input  logic [DATA_W-1:0]            corePeekData,
  input  logic [DATA_W-1:0]            dmaPeekData,
  input  logic [DATA_W-1:0]            coreRdata,
  input  logic [DATA_W-1:0]            dmaRdata,
  output logic [DATA_W-1:0]            wordWdata,
  output logic [DATA_W-1:0]            hostRdata,
  output logic                         hostRvalid,
  output logic                         clrMode
);

  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] shiftedNew;
  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] sizeMask;
  logic [LANES-1:0]  laneEn;

  always_comb begin
    case (region)
      REG_CORE: curWord = corePeekData;
      REG_DMA:  curWord = dmaPeekData;
      REG_CTRL: curWord = ctrlReg;
      default:  curWord = '0;
    endcase
    case (region)
      REG_CORE: rdWord = coreRdata;
      REG_DMA:  rdWord = dmaRdata;
      REG_CTRL: rdWord = ctrlReg;
      default:  rdWord = '0;
    endcase
    shiftedNew = hostWdata << (8 * int'(laneOff));
  end

  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign laneEn[i] = (i >= int'(laneOff)) && (i < int'(laneOff) + int'(hostSize));
    assign mergedWord[8*i +: 8] = laneEn[i] ? shiftedNew[8*i +: 8] : curWord[8*i +: 8];
    assign sizeMask[8*i +: 8]   = (i < int'(hostSize)) ? 8'hFF : 8'h00;
  end

  assign wordWdata = strobe.mergeOn ? mergedWord : hostWdata;
  assign clrMode   = ctrlReg[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      hostRdata  <= '0;
      hostRvalid <= 1'b0;
    end else begin
      if (strobe.ctrlWr) ctrlReg <= wordWdata;
      hostRvalid <= strobe.rdTake;
      if (strobe.rdTake) hostRdata <= (rdWord >> (8 * int'(laneOff))) & sizeMask;
    end
  end

  // R7: read data valid exactly one cycle after a read request
  assert_rvalid_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdTake |=> hostRvalid);
  assert_rvalid_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdTake |=> !hostRvalid);

  // R7: a single-byte read has clear upper bytes
  assert_byte_read_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdTake && hostSize == 3'd1) |=> (hostRdata[DATA_W-1:8] == '0));

  // R3: bus-control word holds unless written
  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ctrlWr |=> $stable(ctrlReg));

endmodule

// File: rtl/io_width_adapter.sv
module io_width_adapter
  import io_adapter_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int CORE_END  = 'h40,
  parameter int DMA_END   = 'h60,
  parameter int CTRL_ADDR = 'h70,
  parameter int CLR_BIT   = 24,
  parameter int CORE_IW   = $clog2(CORE_END / (DATA_W / 8)),
  parameter int DMA_IW    = $clog2((DMA_END - CORE_END) / (DATA_W / 8))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [2:0]        hostSize,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid,
  output logic              clrMode,
  output logic [CORE_IW-1:0] coreIdx,
  output logic              coreRdEn,
  output logic              coreWrEn,
  output logic [DATA_W-1:0] coreWdata,
  input  logic [DATA_W-1:0] coreRdata,
  output logic [CORE_IW-1:0] corePeekIdx,
  input  logic [DATA_W-1:0] corePeekData,
  output logic [DMA_IW-1:0] dmaIdx,
  output logic              dmaRdEn,
  output logic              dmaWrEn,
  output logic [DATA_W-1:0] dmaWdata,
  input  logic [DATA_W-1:0] dmaRdata,
  output logic [DMA_IW-1:0] dmaPeekIdx,
  input  logic [DATA_W-1:0] dmaPeekData
);

  localparam int LANES = DATA_W / 8;
  localparam int LB    = $clog2(LANES);

  region_e           region;
  strobe_t           strobe;
  logic [DATA_W-1:0] wordWdata;
  logic [ADDR_W-1:0] dmaRel;

  io_adapter_ctrl #(
    .ADDR_W(ADDR_W), .LANES(LANES), .CORE_END(CORE_END),
    .DMA_END(DMA_END), .CTRL_ADDR(CTRL_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostSize(hostSize), .region(region), .strobe(strobe)
  );

  io_adapter_dp #(.DATA_W(DATA_W), .CLR_BIT(CLR_BIT)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .region(region),
    .laneOff(hostAddr[LB-1:0]), .hostSize(hostSize), .hostWdata(hostWdata),
    .corePeekData(corePeekData), .dmaPeekData(dmaPeekData),
    .coreRdata(coreRdata), .dmaRdata(dmaRdata), .wordWdata(wordWdata),
    .hostRdata(hostRdata), .hostRvalid(hostRvalid), .clrMode(clrMode)
  );

  assign dmaRel      = hostAddr - ADDR_W'(CORE_END);
  assign coreIdx     = hostAddr[LB +: CORE_IW];
  assign corePeekIdx = hostAddr[LB +: CORE_IW];
  assign dmaIdx      = dmaRel[LB +: DMA_IW];
  assign dmaPeekIdx  = dmaRel[LB +: DMA_IW];
  assign coreRdEn    = strobe.coreRd;
  assign coreWrEn    = strobe.coreWr;
  assign dmaRdEn     = strobe.dmaRd;
  assign dmaWrEn     = strobe.dmaWr;
  assign coreWdata   = wordWdata;
  assign dmaWdata    = wordWdata;

endmodule

// File: tb/io_width_adapter_test.sv
module io_width_adapter_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0, hostWrite = 1'b0;
  logic [6:0]  hostAddr = '0;
  logic [2:0]  hostSize = 3'd4;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostRvalid, clrMode;
  logic [3:0]  coreIdx, corePeekIdx;
  logic        coreRdEn, coreWrEn, dmaRdEn, dmaWrEn;
  logic [31:0] coreWdata, dmaWdata, coreRdata, dmaRdata, corePeekData, dmaPeekData;
  logic [2:0]  dmaIdx, dmaPeekIdx;

  logic [31:0] coreMem [16];
  logic [31:0] dmaMem  [8];
  logic [31:0] coreExp [16];
  logic [31:0] dmaExp  [8];
  logic [31:0] ctrlExp;

  int total = 0, bad = 0;
  int rdInWrite = 0, strayStrobe = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_width_adapter uut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostRvalid(hostRvalid), .clrMode(clrMode),
    .coreIdx(coreIdx), .coreRdEn(coreRdEn), .coreWrEn(coreWrEn), .coreWdata(coreWdata),
    .coreRdata(coreRdata), .corePeekIdx(corePeekIdx), .corePeekData(corePeekData),
    .dmaIdx(dmaIdx), .dmaRdEn(dmaRdEn), .dmaWrEn(dmaWrEn), .dmaWdata(dmaWdata),
    .dmaRdata(dmaRdata), .dmaPeekIdx(dmaPeekIdx), .dmaPeekData(dmaPeekData)
  );

  function automatic logic [31:0] initVal(input int k);
    return (32'h9E3779B9 * (k + 1)) ^ 32'h5A5A0F0F;
  endfunction

  assign coreRdata    = coreMem[coreIdx];
  assign corePeekData = coreMem[corePeekIdx];
  assign dmaRdata     = dmaMem[dmaIdx];
  assign dmaPeekData  = dmaMem[dmaPeekIdx];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 16; k++) coreMem[k] <= initVal(k);
      for (int k = 0; k < 8; k++)  dmaMem[k]  <= initVal(k + 16);
    end else begin
      if (coreWrEn) coreMem[coreIdx] <= coreWdata;
      if (dmaWrEn)  dmaMem[dmaIdx]   <= dmaWdata;
      // R8: no read strobe during a write
      if (hostValid && hostWrite && (coreRdEn || dmaRdEn)) rdInWrite++;
      // R4 / R9: unmapped offsets or bad sizes raise no strobe
      if (hostValid && ((hostAddr >= 7'h60 && hostAddr[6:2] != 5'd28) ||
                        hostSize == 3'd0 || hostSize > 3'd4) &&
          (coreRdEn || coreWrEn || dmaRdEn || dmaWrEn)) strayStrobe++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input logic [6:0] a);
    if (a < 7'h40)           return coreExp[a[5:2]];
    else if (a < 7'h60)      return dmaExp[a[4:2]];
    else if (a[6:2] == 5'd28) return ctrlExp;
    return 32'h0;
  endfunction

  function automatic logic [31:0] sizeMaskOf(input logic [2:0] sz);
    return (sz >= 3'd4) ? 32'hFFFFFFFF : ((32'h1 << (8 * sz)) - 32'h1);
  endfunction

  function automatic logic [31:0] mergeOf(input logic [31:0] cur, input logic [6:0] a,
                                          input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] m;
    m = sizeMaskOf(sz) << (8 * a[1:0]);
    return (cur & ~m) | ((d << (8 * a[1:0])) & m);
  endfunction

  task automatic applyExp(input logic [6:0] a, input logic [2:0] sz, input logic [31:0] d);
    if (sz == 3'd0 || sz > 3'd4) return;
    if (a < 7'h40)            coreExp[a[5:2]] = mergeOf(coreExp[a[5:2]], a, sz, d);
    else if (a < 7'h60)       dmaExp[a[4:2]]  = mergeOf(dmaExp[a[4:2]], a, sz, d);
    else if (a[6:2] == 5'd28) ctrlExp         = mergeOf(ctrlExp, a, sz, d);
  endtask

  // one access; returns data and valid sampled at the following negedge
  task automatic access(input bit wr, input logic [6:0] a, input logic [2:0] sz,
                        input logic [31:0] d, output logic [31:0] rd, output logic rv);
    @(negedge clk);
    hostValid = 1'b1; hostWrite = wr; hostAddr = a; hostSize = sz; hostWdata = d;
    @(negedge clk);
    hostValid = 1'b0; hostWrite = 1'b0;
    rd = hostRdata; rv = hostRvalid;
    if (wr) applyExp(a, sz, d);
  endtask

  task automatic doWrite(input logic [6:0] a, input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] rd; logic rv;
    access(1'b1, a, sz, d, rd, rv);
  endtask

  task automatic doRead(input logic [6:0] a, input logic [2:0] sz, input string tag);
    logic [31:0] rd, exp; logic rv;
    exp = (expWord(a) >> (8 * a[1:0])) & sizeMaskOf(sz);
    access(1'b0, a, sz, 32'h0, rd, rv);
    check(rv === 1'b1, {tag, " rvalid"}, {31'h0, rv}, 32'h1);
    check(rd === exp, tag, rd, exp);
  endtask

  task automatic checkMems(input string tag);
    bit ok = 1'b1;
    for (int k = 0; k < 16; k++) if (coreMem[k] !== coreExp[k]) ok = 1'b0;
    for (int k = 0; k < 8; k++)  if (dmaMem[k] !== dmaExp[k]) ok = 1'b0;
    check(ok, tag, {31'h0, ok}, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic rv; int unused;
    unused = $urandom(1234);
    for (int k = 0; k < 16; k++) coreExp[k] = initVal(k);
    for (int k = 0; k < 8; k++)  dmaExp[k]  = initVal(k + 16);
    ctrlExp = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check(hostRvalid === 1'b0, "R7 reset rvalid", {31'h0, hostRvalid}, 32'h0);
    check(clrMode === 1'b0, "R3 reset clrMode", {31'h0, clrMode}, 32'h0);
    doRead(7'h70, 3'd4, "R3 reset ctrl word");

    // R5 full aligned write, R1 full read
    doWrite(7'h0C, 3'd4, 32'hCAFEF00D);
    check(coreMem[3] === 32'hCAFEF00D, "R5 full write", coreMem[3], 32'hCAFEF00D);
    doRead(7'h0C, 3'd4, "R1 core full read");

    // R6 byte at lane 3, half-word at lane 2
    doWrite(7'h0F, 3'd1, 32'hFFFFFF77);
    check(coreMem[3] === 32'h77FEF00D, "R6 byte lane 3", coreMem[3], 32'h77FEF00D);
    doWrite(7'h4A, 3'd2, 32'h1234BEEF);
    check(dmaMem[2] === mergeOf(initVal(18), 7'h4A, 3'd2, 32'h1234BEEF),
          "R6 half lane 2", dmaMem[2], mergeOf(initVal(18), 7'h4A, 3'd2, 32'h1234BEEF));
    doWrite(7'h5D, 3'd3, 32'hAABBCCDD);
    checkMems("R2 R6 dma three-byte merge");

    // R7 narrow reads, R2 dma index
    doRead(7'h41, 3'd1, "R7 R2 dma byte lane 1");
    doRead(7'h4A, 3'd2, "R7 dma half lane 2");
    doRead(7'h0E, 3'd2, "R7 core half lane 2");

    // R3 control word, bit 24 drives clrMode
    doWrite(7'h73, 3'd1, 32'h00000001);
    check(clrMode === 1'b1, "R3 clrMode set", {31'h0, clrMode}, 32'h1);
    doRead(7'h70, 3'd4, "R3 ctrl readback");
    doWrite(7'h70, 3'd2, 32'h0000ABCD);
    check(clrMode === 1'b1, "R3 clrMode kept by low write", {31'h0, clrMode}, 32'h1);
    doRead(7'h72, 3'd2, "R3 ctrl upper half");

    // R4 unmapped offsets
    doWrite(7'h64, 3'd4, 32'hDEADBEEF);
    doWrite(7'h7C, 3'd1, 32'h000000EE);
    doRead(7'h64, 3'd4, "R4 unmapped read 0x64");
    doRead(7'h75, 3'd1, "R4 unmapped read 0x75");
    checkMems("R4 unmapped writes dropped");
    doRead(7'h70, 3'd4, "R4 ctrl untouched");

    // R9 illegal sizes
    doWrite(7'h00, 3'd0, 32'h11111111);
    doWrite(7'h44, 3'd5, 32'h22222222);
    checkMems("R9 bad size write ignored");
    access(1'b0, 7'h00, 3'd7, 32'h0, rd, rv);
    check(rv === 1'b0, "R9 bad size read no rvalid", {31'h0, rv}, 32'h0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0] sz; logic [1:0] off; logic [6:0] a; logic [31:0] d;
      sz  = 3'(1 + $urandom % 4);
      off = 2'($urandom % (5 - sz));
      a   = {5'($urandom % 32), off};
      d   = $urandom;
      if ($urandom % 2) doWrite(a, sz, d);
      else doRead(a, sz, "R7 random read");
      if (n % 40 == 39) checkMems("R6 random memory image");
      check(clrMode === ctrlExp[24], "R3 random clrMode", {31'h0, clrMode}, {31'h0, ctrlExp[24]});
    end
    checkMems("R6 final memory image");

    check(rdInWrite == 0, "R8 read strobe during write", rdInWrite, 0);
    check(strayStrobe == 0, "R4 R9 stray strobe", strayStrobe, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule